// File: doc/BRIEF.md
# Hold-Arbitrated Coefficient Memory Access Port

This block places a 256-word, 16-bit coefficient memory behind two processor-visible registers. One register holds the word to store. The other takes an indirect address. Loading the indirect address launches one transfer. The top bit of that address selects the direction. A write copies the held word into the memory. A read copies the addressed word into a read-back register that the processor sees on `rdData`. The transfer takes effect only when a page field in the indirect address names the coefficient page.

A hold bit in a control register decides who owns the memory port. While hold is set, the processor may read and write, and the channel output is frozen. While hold is clear, the channel filter drives the memory address and receives coefficients one clock later, and processor strobes leave the memory untouched. Each launched transfer raises `busy` for a fixed recovery window. Loads of the data or address register during that window are dropped.

Top module: `coef_ram_port`

## Requirements
- R1: A register write to offset 0x0C sets hold mode to bit 12 of the written word. Writes to this offset are accepted even while busy.
- R2: A register write to offset 0x14 that is accepted (not busy) loads the 16-bit data holding register.
- R3: An accepted register write to offset 0x15 loads the indirect address and launches exactly one transfer on the next clock edge. With address bit 15 = 0, the memory word at address bits [7:0] takes the data holding register.
- R4: With address bit 15 = 1, the launched transfer loads the read-back register from the memory word at address bits [7:0]. `rdData` shows it from the second clock edge after the address write. It stays unchanged until the next effective read transfer.
- R5: A transfer whose page field, address bits [10:8], is not 3 changes neither the memory nor `rdData`.
- R6: `busy` is high for exactly 4 cycles, starting on the edge that accepts an address write. Writes to offsets 0x14 and 0x15 that arrive while `busy` is high are ignored.
- R7: While hold mode is clear, launched transfers change neither the memory nor `rdData`.
- R8: While hold mode is clear, `chanData` shows the memory word at `chanAddr` one clock edge after it is presented. While hold mode is set, `chanData` stays unchanged.
- R9: After reset, hold mode is clear, `busy` is low, and `rdData` and `chanData` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write enable |
| regAddr | input | 5 | Register offset (0x0C control, 0x14 data, 0x15 indirect address) |
| regWdata | input | 16 | Register write data |
| rdData | output | 16 | Read-back register |
| busy | output | 1 | Transfer recovery window active |
| chanAddr | input | 8 | Channel coefficient address |
| chanData | output | 16 | Channel coefficient, one cycle latency |

## Verification
The bench builds the block with its default parameters: a 256-entry memory, 16-bit words, a page field of three bits above the word index, and a 4-cycle busy window. It fills every memory location through the processor path. This lets the channel sweep and the read-backs reach both ends of the address range. The short busy window allows loads to be aimed at the first and last cycles of the window. Page values below and above the coefficient page are used to show that near-miss pages are rejected.

// File: rtl/coef_port_pkg.sv
package coef_port_pkg;
  // Strobes from the control side to the datapath side
  typedef struct packed {
    logic loadData;  // accepted write to the data holding register
    logic loadAddr;  // accepted write to the indirect address register
    logic xfer;      // transfer strobe, one cycle after loadAddr
    logic hold;      // processor owns the memory port
  } portCtl_t;
endpackage

// File: rtl/coef_port_ctrl.sv
module coef_port_ctrl
  import coef_port_pkg::*;
#(
  parameter int REG_AW   = 5,
  parameter int DATA_W   = 16,
  parameter int BUSY_CYC = 4,
  parameter int CTRL_OFS = 'h0c,
  parameter int DATA_OFS = 'h14,
  parameter int ADDR_OFS = 'h15,
  parameter int HOLD_BIT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic              busy,
  output portCtl_t          ctl
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic             holdMode;
  logic             xferQ;
  logic [CNT_W-1:0] busyCnt;
  logic             busyNow;
  logic             ctrlHit;
  logic             dataHit;
  logic             addrHit;

  assign busyNow = (busyCnt != '0);
  assign ctrlHit = regWe && (regAddr == REG_AW'(CTRL_OFS));
  assign dataHit = regWe && (regAddr == REG_AW'(DATA_OFS)) && !busyNow;
  assign addrHit = regWe && (regAddr == REG_AW'(ADDR_OFS)) && !busyNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdMode <= 1'b0;
      xferQ    <= 1'b0;
      busyCnt  <= '0;
    end else begin
      if (ctrlHit) holdMode <= regWdata[HOLD_BIT];
      xferQ <= addrHit;
      if (addrHit)      busyCnt <= CNT_W'(BUSY_CYC);
      else if (busyNow) busyCnt <= busyCnt - 1'b1;
    end
  end

  assign busy         = busyNow;
  assign ctl.loadData = dataHit;
  assign ctl.loadAddr = addrHit;
  assign ctl.xfer     = xferQ;
  assign ctl.hold     = holdMode;

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadAddr |=> busy);
  // R6
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!ctl.loadData && !ctl.loadAddr));
  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy);
  // R3
  xfer_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.xfer |-> $past(ctl.loadAddr));
endmodule

// File: rtl/coef_port_dp.sv
module coef_port_dp
  import coef_port_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int RAM_AW  = 8,
  parameter int PAGE_W  = 3,
  parameter int PAGE_ID = 3,
  parameter int RW_BIT  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  portCtl_t          ctl,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [RAM_AW-1:0] chanAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] chanData
);
  localparam int DEPTH = 1 << RAM_AW;
  localparam int PG_LO = RAM_AW;
  localparam int PG_HI = RAM_AW + PAGE_W - 1;

  logic [DATA_W-1:0] coefMem [DEPTH];
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] addrReg;
  logic [DATA_W-1:0] rdBack;
  logic [DATA_W-1:0] chanQ;
  logic [RAM_AW-1:0] wordIdx;
  logic [RAM_AW-1:0] memAddr;
  logic              pageOk;
  logic              doWrite;
  logic              doRead;

  assign wordIdx = addrReg[RAM_AW-1:0];
  assign pageOk  = (addrReg[PG_HI:PG_LO] == PAGE_W'(PAGE_ID));
  assign doWrite = ctl.xfer && ctl.hold && pageOk && !addrReg[RW_BIT];
  assign doRead  = ctl.xfer && ctl.hold && pageOk &&  addrReg[RW_BIT];
  assign memAddr = ctl.hold ? wordIdx : chanAddr;

  always_ff @(posedge clk) begin
    if (doWrite) coefMem[wordIdx] <= dataReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      addrReg <= '0;
      rdBack  <= '0;
      chanQ   <= '0;
    end else begin
      if (ctl.loadData) dataReg <= regWdata;
      if (ctl.loadAddr) addrReg <= regWdata;
      if (doRead)       rdBack  <= coefMem[memAddr];
      if (!ctl.hold)    chanQ   <= coefMem[memAddr];
    end
  end

  assign rdData   = rdBack;
  assign chanData = chanQ;

  // R8
  chan_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hold |=> $stable(chanData));
  // R4
  rdback_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.xfer |=> $stable(rdData));
endmodule

// File: rtl/coef_ram_port.sv
module coef_ram_port
  import coef_port_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int RAM_AW   = 8,
  parameter int REG_AW   = 5,
  parameter int BUSY_CYC = 4,
  parameter int PAGE_W   = 3,
  parameter int PAGE_ID  = 3,
  parameter int HOLD_BIT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  input  logic [RAM_AW-1:0] chanAddr,
  output logic [DATA_W-1:0] chanData
);
  localparam int RW_BIT = DATA_W - 1;

  portCtl_t ctl;

  coef_port_ctrl #(
    .REG_AW(REG_AW), .DATA_W(DATA_W), .BUSY_CYC(BUSY_CYC),
    .CTRL_OFS('h0c), .DATA_OFS('h14), .ADDR_OFS('h15), .HOLD_BIT(HOLD_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .busy(busy), .ctl(ctl)
  );

  coef_port_dp #(
    .DATA_W(DATA_W), .RAM_AW(RAM_AW), .PAGE_W(PAGE_W),
    .PAGE_ID(PAGE_ID), .RW_BIT(RW_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .regWdata(regWdata),
    .chanAddr(chanAddr), .rdData(rdData), .chanData(chanData)
  );
endmodule

// File: tb/coef_ram_port_tb.sv
module coef_ram_port_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] rdData;
  logic        busy;
  logic [7:0]  chanAddr = '0;
  logic [15:0] chanData;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  coef_ram_port u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .rdData(rdData), .busy(busy),
    .chanAddr(chanAddr), .chanData(chanData)
  );

  // Behavioural reference model
  logic [15:0] mRam [256];
  bit          mValid [256];
  logic [15:0] mData, mAddr, mRdBack, mChan;
  bit          mHold, mStrobe, mChanValid;
  int          mCnt;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mData = 0; mAddr = 0; mRdBack = 0; mChan = 0;
      mHold = 0; mStrobe = 0; mChanValid = 1; mCnt = 0;
    end else begin
      bit wasBusy;
      int idx;
      wasBusy = (mCnt != 0);
      idx = mAddr & 16'h00ff;
      if (!mHold) begin
        mChan = mRam[chanAddr];
        mChanValid = mValid[chanAddr];
      end
      if (mStrobe && mHold && (((mAddr >> 8) & 7) == 3)) begin
        if (mAddr[15]) mRdBack = mRam[idx];
        else begin mRam[idx] = mData; mValid[idx] = 1; end
      end
      mStrobe = 0;
      if (mCnt > 0) mCnt--;
      if (regWe) begin
        if (regAddr == 5'h0c) mHold = regWdata[12];
        if (regAddr == 5'h14 && !wasBusy) mData = regWdata;
        if (regAddr == 5'h15 && !wasBusy) begin
          mAddr = regWdata; mStrobe = 1; mCnt = 4;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle compare against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(busy === (mCnt != 0), "R6 busy window", {15'd0, busy}, {15'd0, mCnt != 0});
      chk(rdData === mRdBack, "R4 read-back", rdData, mRdBack);
      if (mChanValid) chk(chanData === mChan, "R8 channel data", chanData, mChan);
    end
  end

  function automatic logic [15:0] pat(input int i);
    return 16'((i * 16'h9e37) ^ 16'h5a5a);
  endfunction

  task automatic regWrite(input logic [4:0] a, input logic [15:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readWord(input logic [15:0] ia);
    regWrite(5'h15, ia);
    idle(4);
  endtask

  task automatic finishRun;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd1, 16'd0);
    finishRun();
  end

  initial begin
    logic [15:0] keep;
    idle(3);
    // R9 reset state
    chk(busy === 1'b0, "R9 busy after reset", {15'd0, busy}, 16'd0);
    chk(rdData === 16'd0, "R9 rdData after reset", rdData, 16'd0);
    chk(chanData === 16'd0, "R9 chanData after reset", chanData, 16'd0);
    rstN = 1'b1;
    idle(2);

    // R1 take the port, R2/R3 fill every word
    regWrite(5'h0c, 16'h1000);
    for (int i = 0; i < 256; i++) begin
      regWrite(5'h14, pat(i));
      regWrite(5'h15, 16'h0300 | 16'(i));
      idle(4);
    end

    // R3/R4 read back both ends and the middle
    readWord(16'h8300);
    chk(rdData === pat(0), "R3 word 0", rdData, pat(0));
    readWord(16'h83ff);
    chk(rdData === pat(255), "R3 word 255", rdData, pat(255));
    readWord(16'h8380);
    chk(rdData === pat(128), "R4 word 128", rdData, pat(128));
    idle(3);
    chk(rdData === pat(128), "R4 read-back stable", rdData, pat(128));

    // R6 busy window length and dropped loads
    regWrite(5'h14, 16'h1111);
    regWrite(5'h15, 16'h0310);
    chk(busy === 1'b1, "R6 busy after address write", {15'd0, busy}, 16'd1);
    regWrite(5'h14, 16'hdead);   // dropped
    regWrite(5'h15, 16'h0311);   // dropped
    idle(1);
    chk(busy === 1'b1, "R6 busy last cycle", {15'd0, busy}, 16'd1);
    idle(1);
    chk(busy === 1'b0, "R6 busy released", {15'd0, busy}, 16'd0);
    regWrite(5'h15, 16'h0312);
    idle(4);
    readWord(16'h8312);
    chk(rdData === 16'h1111, "R6 data load during busy ignored", rdData, 16'h1111);
    readWord(16'h8311);
    chk(rdData === pat('h11), "R6 address load during busy ignored", rdData, pat('h11));
    readWord(16'h8310);
    chk(rdData === 16'h1111, "R2 data register write", rdData, 16'h1111);

    // R1 control write accepted while busy
    regWrite(5'h15, 16'h8320);
    regWrite(5'h0c, 16'h0000);
    idle(4);
    chanAddr = 8'h20;
    idle(1);
    chk(chanData === pat('h20), "R1 hold cleared while busy", chanData, pat('h20));
    regWrite(5'h0c, 16'h1000);

    // R5 neighbouring pages do nothing
    regWrite(5'h14, 16'hbeef);
    regWrite(5'h15, 16'h0240);
    idle(4);
    regWrite(5'h15, 16'h0740);
    idle(4);
    readWord(16'h8340);
    chk(rdData === pat('h40), "R5 off-page write ignored", rdData, pat('h40));
    readWord(16'h8441);
    chk(rdData === pat('h40), "R5 off-page read ignored", rdData, pat('h40));

    // R7 strobes with hold clear
    regWrite(5'h0c, 16'h0000);
    regWrite(5'h14, 16'h7777);
    regWrite(5'h15, 16'h0305);
    idle(4);
    regWrite(5'h15, 16'h8306);
    idle(4);
    chk(rdData === pat('h40), "R7 read ignored without hold", rdData, pat('h40));
    chanAddr = 8'h05;
    idle(1);
    chk(chanData === pat(5), "R7 write ignored without hold", chanData, pat(5));

    // R8 channel sweep, one cycle latency
    for (int i = 0; i < 256; i += 51) begin
      chanAddr = 8'(i);
      idle(1);
      keep = mRam[i];
      chk(chanData === keep, "R8 channel sweep", chanData, keep);
    end
    chanAddr = 8'hff;
    idle(1);
    chk(chanData === pat(255), "R8 top word", chanData, pat(255));

    // R8 freeze under hold
    regWrite(5'h0c, 16'h1000);
    keep = chanData;
    chanAddr = 8'h01;
    idle(3);
    chk(chanData === keep, "R8 frozen under hold", chanData, keep);

    idle(2);
    finishRun();
  end
endmodule